// File: doc/BRIEF.md
# Two-bank SDRAM command controller

This block sits between a simple host request port and a synchronous DRAM with two internal banks of 512K 16-bit words each. The host presents one access at a time (a single-beat read or write on a 20-bit word address). The controller opens the addressed row, issues the column command with auto precharge requested, and spaces every command by parameterised minimum gaps counted in clock cycles. Read data comes back on a separate valid/data pair once the programmed CAS latency has passed.

After reset the controller waits a stabilisation period. It then closes both banks, runs a fixed number of auto refresh cycles, writes the mode register and finally the extended mode register. Host requests are refused until that sequence is over. A refresh timer raises a pending flag that is served ahead of new host requests, and only when no access is in flight. While idle, a power-down request lowers the clock enable. Every row is closed after each access, so both banks are always precharged whenever the controller is idle.

Top module: `dualbank_sdram_ctrl`

## Requirements
- R1: While reset is held, `sdCke` is 1, `sdCsN` is 1, and `reqReady` and `rdValid` are 0.
- R2: Start-up issues, in this order: a precharge with `sdAddr[10]`=1, then INIT_REFS refresh commands, then a mode write with `sdBa`=0 and `sdAddr` = CAS_LAT in bits 6:4 and zero elsewhere (bits 2:0 = 000 select one-beat bursts, bit 3 = 0 sequential), then a mode write with `sdBa`=1 and `sdAddr` = EXT_MODE. The second mode write comes exactly T_MRD cycles after the first. `reqReady` stays 0 until the second mode write has been issued.
- R3: An activate drives `sdBa`=reqAddr[19], `sdAddr[10:0]`=reqAddr[18:8] and `sdAddr[11]`=0. The following read or write drives the same bank, `sdAddr[7:0]`=reqAddr[7:0] and `sdAddr[10]`=1 (auto precharge).
- R4: In the cycle a write command is on the pins, `sdDqOe`=1, `sdDqm`=0 and `sdDqOut` holds the request's write data. `sdDqOe` is 0 at all other times.
- R5: The bus value sampled CAS_LAT cycles after a read command is returned on `rdData` with `rdValid` high one cycle later. Read results come back in request order.
- R6: A read or write command follows its activate by exactly T_RCD cycles.
- R7: An activate or refresh comes at least T_RC cycles after an activate or refresh, at least T_RDL+T_RP cycles after a read or write, and at least T_RP cycles after a precharge. Any command comes at least T_MRD cycles after a mode write.
- R8: A refresh becomes pending every REF_INTERVAL cycles. It stays pending until a refresh is issued, and it is issued ahead of waiting host requests.
- R9: With `pdReq` high, no pending refresh and no request, an idle controller drives `sdCke` low and keeps rasN/casN/weN high while it is low. A due refresh brings `sdCke` back up, and at least one cycle with `sdCke` high passes before the next command.
- R10: A request made while `pdReq` is high is still served, with correct data.
- R11: `reqReady` is high only in the idle state with every timer expired and no refresh pending. It drops in the cycle after a request is accepted.
- R12: Commands use (csN,rasN,casN,weN) codes: activate 0011, read 0101, write 0100, precharge 0010, refresh 0001, mode write 0000, no-op 0111. No other code is driven while csN=0 and `sdCke`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| reqValid | input | 1 | Host request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 20 | Word address: bank, row, column |
| reqWdata | input | 16 | Write data |
| reqReady | output | 1 | Request accepted at this edge when valid |
| rdValid | output | 1 | Read data valid |
| rdData | output | 16 | Read data |
| pdReq | input | 1 | Request power-down while idle |
| sdCke | output | 1 | Memory clock enable |
| sdCsN | output | 1 | Chip select, active low |
| sdRasN | output | 1 | Row strobe, active low |
| sdCasN | output | 1 | Column strobe, active low |
| sdWeN | output | 1 | Write enable, active low |
| sdBa | output | 1 | Bank select |
| sdAddr | output | 12 | Memory address; bit 10 is the precharge flag |
| sdDqm | output | 1 | Data mask |
| sdDqOut | output | 16 | Data to memory |
| sdDqOe | output | 1 | Data output enable |
| sdDqIn | input | 16 | Data from memory |

## Verification
The embedded properties check on every cycle that column commands sit exactly T_RCD after their activate, and that the second mode write follows the first by T_MRD. They also check that the pending refresh flag is never dropped without a refresh, that a low clock enable carries only no-ops, that write data is driven only with a write command, and that read results line up with the CAS latency. The minimum gaps between different command types, the order of the start-up sequence, the address split, data integrity across both banks, refresh rate, and power-down entry and exit around refresh and host traffic are shown only by the bench's scenarios against its own two-bank memory model.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

  typedef enum logic [2:0] {
    CMD_NOP, CMD_ACT, CMD_RD, CMD_WR, CMD_PRE, CMD_REF, CMD_MRS, CMD_EMRS
  } sdCmd_e;

  // Strobes from control to datapath, one set per cycle
  typedef struct packed {
    sdCmd_e cmd;
    logic   latchReq;
    logic   ckeOn;
    logic   maskDq;
  } ctlStrobe_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdc_control.sv
module sdc_control
  import sdc_pkg::*;
#(
  parameter int T_RCD        = 2,
  parameter int T_RP         = 2,
  parameter int T_RC         = 7,
  parameter int T_RDL        = 2,
  parameter int T_MRD        = 2,
  parameter int INIT_WAIT    = 20000,
  parameter int INIT_REFS    = 2,
  parameter int REF_INTERVAL = 780
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  input  logic       pdReq,
  output logic       reqReady,
  output ctlStrobe_t strobe
);

  localparam int RW_GAP = maxOf(T_RDL + T_RP, T_RC - T_RCD);
  localparam int MAXW   = maxOf(maxOf(maxOf(INIT_WAIT, T_RC), maxOf(RW_GAP, T_RCD)),
                                maxOf(maxOf(T_RP, T_MRD), 2));
  localparam int CW     = $clog2(MAXW + 1);
  localparam int RFW    = $clog2(REF_INTERVAL + 1);
  localparam int IRW    = $clog2(INIT_REFS + 1);

  typedef enum logic [2:0] {
    ST_PWR, ST_IREF, ST_IMRS, ST_IEMRS, ST_IDLE, ST_ACTD, ST_PD
  } state_e;

  state_e          state, nextState;
  logic [CW-1:0]   cnt, loadVal;
  logic            doLoad;
  logic [IRW-1:0]  initRefs;
  logic [RFW-1:0]  refTimer;
  logic            refPending, refServe, isWrite;

  always_comb begin
    nextState = state;
    strobe    = '0;
    strobe.ckeOn  = 1'b1;
    strobe.maskDq = (state == ST_PWR) || (state == ST_IREF) ||
                    (state == ST_IMRS) || (state == ST_IEMRS);
    doLoad   = 1'b0;
    loadVal  = '0;
    refServe = 1'b0;
    case (state)
      ST_PWR: if (cnt == '0) begin
        strobe.cmd = CMD_PRE; doLoad = 1'b1; loadVal = CW'(T_RP - 1);
        nextState = ST_IREF;
      end
      ST_IREF: if (cnt == '0) begin
        strobe.cmd = CMD_REF; doLoad = 1'b1; loadVal = CW'(T_RC - 1);
        if (initRefs == IRW'(INIT_REFS - 1)) nextState = ST_IMRS;
      end
      ST_IMRS: if (cnt == '0) begin
        strobe.cmd = CMD_MRS; doLoad = 1'b1; loadVal = CW'(T_MRD - 1);
        nextState = ST_IEMRS;
      end
      ST_IEMRS: if (cnt == '0) begin
        strobe.cmd = CMD_EMRS; doLoad = 1'b1; loadVal = CW'(T_MRD - 1);
        nextState = ST_IDLE;
      end
      ST_IDLE: if (cnt == '0) begin
        if (refPending) begin
          strobe.cmd = CMD_REF; doLoad = 1'b1; loadVal = CW'(T_RC - 1);
          refServe = 1'b1;
        end else if (reqValid) begin
          strobe.cmd = CMD_ACT; strobe.latchReq = 1'b1;
          doLoad = 1'b1; loadVal = CW'(T_RCD - 1);
          nextState = ST_ACTD;
        end else if (pdReq) begin
          nextState = ST_PD;
        end
      end
      ST_ACTD: if (cnt == '0) begin
        strobe.cmd = isWrite ? CMD_WR : CMD_RD;
        doLoad = 1'b1; loadVal = CW'(RW_GAP - 1);
        nextState = ST_IDLE;
      end
      ST_PD: begin
        strobe.ckeOn = 1'b0;
        if (!pdReq || refPending || reqValid) begin
          // raise clock enable and hold one no-op cycle before any command
          strobe.ckeOn = 1'b1; doLoad = 1'b1; loadVal = CW'(1);
          nextState = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign reqReady = (state == ST_IDLE) && (cnt == '0) && !refPending;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_PWR;
      cnt        <= CW'(INIT_WAIT - 1);
      initRefs   <= '0;
      refTimer   <= RFW'(REF_INTERVAL - 1);
      refPending <= 1'b0;
      isWrite    <= 1'b0;
    end else begin
      state <= nextState;
      if (doLoad)          cnt <= loadVal;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
      if (state == ST_IREF && strobe.cmd == CMD_REF) initRefs <= initRefs + 1'b1;
      if (refTimer == '0)  refTimer <= RFW'(REF_INTERVAL - 1);
      else                 refTimer <= refTimer - 1'b1;
      refPending <= (refPending && !refServe) || (refTimer == '0);
      if (strobe.latchReq) isWrite <= reqWrite;
    end
  end

  // R6
  rw_after_act_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.cmd == CMD_RD || strobe.cmd == CMD_WR) |-> $past(strobe.cmd == CMD_ACT, T_RCD));

  // R2
  emrs_after_mrs_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.cmd == CMD_EMRS) |-> $past(strobe.cmd == CMD_MRS, T_MRD));

  // R8
  ref_pending_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (refPending && strobe.cmd != CMD_REF) |=> refPending);

  // R11
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

endmodule

// File: rtl/sdc_datapath.sv
module sdc_datapath
  import sdc_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int COL_W   = 8,
  parameter int DATA_W  = 16,
  parameter int SD_A_W  = 12,
  parameter int CAS_LAT = 2,
  parameter logic [SD_A_W-1:0] EXT_MODE = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] sdDqIn,
  output logic              sdCke,
  output logic              sdCsN,
  output logic              sdRasN,
  output logic              sdCasN,
  output logic              sdWeN,
  output logic              sdBa,
  output logic [SD_A_W-1:0] sdAddr,
  output logic              sdDqm,
  output logic [DATA_W-1:0] sdDqOut,
  output logic              sdDqOe,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData
);

  localparam int AP_BIT = 10;  // row bit that doubles as the precharge flag
  localparam logic [SD_A_W-1:0] AP_MASK   = SD_A_W'(1) << AP_BIT;
  localparam logic [SD_A_W-1:0] MODE_WORD = SD_A_W'(CAS_LAT << 4);

  logic [3:0]        nCmd;
  logic              nBa;
  logic [SD_A_W-1:0] nA;
  logic              bankReg;
  logic [COL_W-1:0]  colReg;
  logic [DATA_W-1:0] wdReg;
  logic [CAS_LAT-1:0] rdShift;

  always_comb begin
    nCmd = 4'b0111;
    nBa  = 1'b0;
    nA   = '0;
    case (strobe.cmd)
      CMD_ACT: begin
        nCmd = 4'b0011; nBa = reqAddr[ADDR_W-1];
        nA = SD_A_W'(reqAddr[ADDR_W-2:COL_W]);
      end
      CMD_RD:  begin nCmd = 4'b0101; nBa = bankReg; nA = SD_A_W'(colReg) | AP_MASK; end
      CMD_WR:  begin nCmd = 4'b0100; nBa = bankReg; nA = SD_A_W'(colReg) | AP_MASK; end
      CMD_PRE: begin nCmd = 4'b0010; nA = AP_MASK; end
      CMD_REF: nCmd = 4'b0001;
      CMD_MRS: begin nCmd = 4'b0000; nA = MODE_WORD; end
      CMD_EMRS: begin nCmd = 4'b0000; nBa = 1'b1; nA = EXT_MODE; end
      default: nCmd = 4'b0111;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      {sdCsN, sdRasN, sdCasN, sdWeN} <= 4'b1111;
      sdCke   <= 1'b1;
      sdBa    <= 1'b0;
      sdAddr  <= '0;
      sdDqm   <= 1'b1;
      sdDqOe  <= 1'b0;
      sdDqOut <= '0;
      bankReg <= 1'b0;
      colReg  <= '0;
      wdReg   <= '0;
      rdShift <= '0;
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      {sdCsN, sdRasN, sdCasN, sdWeN} <= nCmd;
      sdCke   <= strobe.ckeOn;
      sdBa    <= nBa;
      sdAddr  <= nA;
      sdDqm   <= strobe.maskDq;
      sdDqOe  <= (strobe.cmd == CMD_WR);
      sdDqOut <= wdReg;
      if (strobe.latchReq) begin
        bankReg <= reqAddr[ADDR_W-1];
        colReg  <= reqAddr[COL_W-1:0];
        wdReg   <= reqWdata;
      end
      rdShift <= {rdShift[CAS_LAT-2:0], strobe.cmd == CMD_RD};
      rdValid <= rdShift[CAS_LAT-1];
      if (rdShift[CAS_LAT-1]) rdData <= sdDqIn;
    end
  end

  // R5
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past({sdCsN, sdRasN, sdCasN, sdWeN} == 4'b0101, CAS_LAT));

  // R9
  pd_nop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sdCke |-> ({sdRasN, sdCasN, sdWeN} == 3'b111));

  // R4
  dq_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    sdDqOe |-> ({sdCsN, sdRasN, sdCasN, sdWeN} == 4'b0100 && !sdDqm));

endmodule

// File: rtl/dualbank_sdram_ctrl.sv
module dualbank_sdram_ctrl
  import sdc_pkg::*;
#(
  parameter int ADDR_W       = 20,
  parameter int COL_W        = 8,
  parameter int DATA_W       = 16,
  parameter int SD_A_W       = 12,
  parameter int CAS_LAT      = 2,
  parameter int T_RCD        = 2,
  parameter int T_RP         = 2,
  parameter int T_RC         = 7,
  parameter int T_RDL        = 2,
  parameter int T_MRD        = 2,
  parameter int INIT_WAIT    = 20000,
  parameter int INIT_REFS    = 2,
  parameter int REF_INTERVAL = 780,
  parameter logic [SD_A_W-1:0] EXT_MODE = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqReady,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  input  logic              pdReq,
  output logic              sdCke,
  output logic              sdCsN,
  output logic              sdRasN,
  output logic              sdCasN,
  output logic              sdWeN,
  output logic              sdBa,
  output logic [SD_A_W-1:0] sdAddr,
  output logic              sdDqm,
  output logic [DATA_W-1:0] sdDqOut,
  output logic              sdDqOe,
  input  logic [DATA_W-1:0] sdDqIn
);

  ctlStrobe_t strobe;

  sdc_control #(
    .T_RCD(T_RCD), .T_RP(T_RP), .T_RC(T_RC), .T_RDL(T_RDL), .T_MRD(T_MRD),
    .INIT_WAIT(INIT_WAIT), .INIT_REFS(INIT_REFS), .REF_INTERVAL(REF_INTERVAL)
  ) u_control (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .pdReq(pdReq), .reqReady(reqReady), .strobe(strobe)
  );

  sdc_datapath #(
    .ADDR_W(ADDR_W), .COL_W(COL_W), .DATA_W(DATA_W), .SD_A_W(SD_A_W),
    .CAS_LAT(CAS_LAT), .EXT_MODE(EXT_MODE)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .sdDqIn(sdDqIn), .sdCke(sdCke), .sdCsN(sdCsN), .sdRasN(sdRasN), .sdCasN(sdCasN),
    .sdWeN(sdWeN), .sdBa(sdBa), .sdAddr(sdAddr), .sdDqm(sdDqm), .sdDqOut(sdDqOut),
    .sdDqOe(sdDqOe), .rdValid(rdValid), .rdData(rdData)
  );

endmodule

// File: tb/dualbank_sdram_ctrl_tb.sv
module dualbank_sdram_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int CL     = 3;
  localparam int TRCD   = 2;
  localparam int TRP    = 2;
  localparam int TRC    = 6;
  localparam int TRDL   = 2;
  localparam int TMRD   = 2;
  localparam int IWAIT  = 30;
  localparam int IREFS  = 2;
  localparam int REFINT = 150;
  localparam logic [11:0] EXTM = 12'h040;
  localparam logic [15:0] BLANK = 16'hDEAD;  // model and shadow value of unwritten words

  logic clk = 0, rstN = 0;
  logic reqValid = 0, reqWrite = 0, pdReq = 0;
  logic [19:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic reqReady, rdValid, sdCke, sdCsN, sdRasN, sdCasN, sdWeN, sdBa, sdDqm, sdDqOe;
  logic [15:0] rdData, sdDqOut, sdDqIn;
  logic [11:0] sdAddr;

  always #(CLK_PERIOD/2) clk = ~clk;

  dualbank_sdram_ctrl #(
    .CAS_LAT(CL), .T_RCD(TRCD), .T_RP(TRP), .T_RC(TRC), .T_RDL(TRDL), .T_MRD(TMRD),
    .INIT_WAIT(IWAIT), .INIT_REFS(IREFS), .REF_INTERVAL(REFINT), .EXT_MODE(EXTM)
  ) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .reqReady(reqReady), .rdValid(rdValid), .rdData(rdData),
    .pdReq(pdReq), .sdCke(sdCke), .sdCsN(sdCsN), .sdRasN(sdRasN), .sdCasN(sdCasN),
    .sdWeN(sdWeN), .sdBa(sdBa), .sdAddr(sdAddr), .sdDqm(sdDqm), .sdDqOut(sdDqOut),
    .sdDqOe(sdDqOe), .sdDqIn(sdDqIn)
  );

  int testsRun = 0, testsFailed = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // memory model, command monitor and scoreboard
  logic [15:0] mem [int];
  logic [15:0] shadow [int];
  logic [15:0] expQ [$];
  logic [15:0] pipe [CL];
  logic [10:0] openRow [2];
  int cyc = 0, lastAct = -1000, lastRw = -1000, lastPre = -1000, lastRef = -1000;
  int lastMrs = -1000, lastCkeLow = -1000, refCount = 0, logN = 0;
  logic [3:0]  logCode [8];
  logic        logBa [8];
  bit emrsSeen = 0, earlyReady = 0;
  logic        expBa = 0;
  logic [10:0] expRow = '0;
  logic [7:0]  expCol = '0;
  logic [3:0]  code;
  logic [15:0] got;
  int key;

  assign sdDqIn = pipe[0];

  initial begin
    for (int i = 0; i < CL; i++) pipe[i] = '0;
    openRow[0] = '0; openRow[1] = '0;
  end

  always @(negedge clk) begin
    cyc++;
    for (int i = 0; i < CL - 1; i++) pipe[i] = pipe[i+1];
    pipe[CL-1] = '0;
    code = {sdCsN, sdRasN, sdCasN, sdWeN};
    if (rstN) begin
      if (reqReady && !emrsSeen) earlyReady = 1;
      if (!sdCke) begin
        lastCkeLow = cyc;
        chk(code[2:0] == 3'b111, "R9", "pins while cke low", code, 4'b0111);
      end else if (!sdCsN && code != 4'b0111) begin
        if (logN < 8) begin logCode[logN] = code; logBa[logN] = sdBa; logN++; end
        case (code)
          4'b0011, 4'b0001: begin
            chk(cyc - lastAct >= TRC, "R7", "gap after activate", cyc - lastAct, TRC);
            chk(cyc - lastRef >= TRC, "R7", "gap after refresh", cyc - lastRef, TRC);
            chk(cyc - lastRw >= TRDL + TRP, "R7", "gap after column cmd", cyc - lastRw, TRDL + TRP);
            chk(cyc - lastPre >= TRP, "R7", "gap after precharge", cyc - lastPre, TRP);
            chk(cyc - lastMrs >= TMRD, "R7", "gap after mode write", cyc - lastMrs, TMRD);
            chk(cyc - lastCkeLow >= 2, "R9", "nop cycle after cke rise", cyc - lastCkeLow, 2);
            if (code == 4'b0011) begin
              chk(sdBa == expBa, "R3", "activate bank", sdBa, expBa);
              chk(sdAddr == {1'b0, expRow}, "R3", "activate row", sdAddr, {1'b0, expRow});
              openRow[sdBa] = sdAddr[10:0];
              lastAct = cyc;
            end else begin
              refCount++;
              lastRef = cyc;
            end
          end
          4'b0101, 4'b0100: begin
            chk(cyc - lastAct == TRCD, "R6", "activate to column", cyc - lastAct, TRCD);
            chk(sdBa == expBa, "R3", "column bank", sdBa, expBa);
            chk(sdAddr[7:0] == expCol && sdAddr[10], "R3", "column addr/autoprecharge",
                sdAddr, {4'b0100, expCol});
            key = int'({sdBa, openRow[sdBa], sdAddr[7:0]});
            if (code == 4'b0100) begin
              chk(sdDqOe && !sdDqm, "R4", "write drive oe/dqm", {sdDqOe, sdDqm}, 2'b10);
              mem[key] = sdDqOut;
            end else begin
              pipe[CL-1] = mem.exists(key) ? mem[key] : BLANK;
            end
            lastRw = cyc;
          end
          4'b0010: begin
            chk(sdAddr[10], "R2", "precharge all flag", sdAddr[10], 1);
            lastPre = cyc;
          end
          4'b0000: begin
            chk(cyc - lastMrs >= TMRD, "R7", "mode write spacing", cyc - lastMrs, TMRD);
            if (!sdBa) chk(sdAddr == 12'(CL << 4), "R2", "mode word", sdAddr, 12'(CL << 4));
            else begin
              chk(sdAddr == EXTM, "R2", "extended mode word", sdAddr, EXTM);
              emrsSeen = 1;
            end
            lastMrs = cyc;
          end
          default: chk(0, "R12", "illegal command code", code, 4'b0111);
        endcase
      end
      if (rdValid) begin
        if (expQ.size() == 0) chk(0, "R5", "unexpected read data", rdData, 0);
        else begin
          got = expQ.pop_front();
          chk(rdData == got, "R5", "read data", rdData, got);
        end
      end
    end
  end

  task automatic access(input bit wr, input logic [19:0] addr, input logic [15:0] data);
    expBa = addr[19]; expRow = addr[18:8]; expCol = addr[7:0];
    if (wr) shadow[int'(addr)] = data;
    else expQ.push_back(shadow.exists(int'(addr)) ? shadow[int'(addr)] : BLANK);
    reqWrite = wr; reqAddr = addr; reqWdata = data; reqValid = 1;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 0;
    chk(!reqReady, "R11", "ready after accept", reqReady, 0);
    repeat (TRCD + 1) @(negedge clk);
  endtask

  int r0;

  initial begin
    repeat (5) @(negedge clk);
    chk(sdCke && sdCsN, "R1", "cke/csN in reset", {sdCke, sdCsN}, 2'b11);
    chk(!reqReady && !rdValid, "R1", "ready/valid in reset", {reqReady, rdValid}, 0);
    rstN = 1;
    while (!reqReady) @(negedge clk);
    chk(!earlyReady, "R2", "ready before init end", earlyReady, 0);
    chk(logN == 5, "R2", "init command count", logN, 5);
    chk(logCode[0] == 4'b0010, "R2", "init step 0 precharge", logCode[0], 4'b0010);
    chk(logCode[1] == 4'b0001 && logCode[2] == 4'b0001, "R2", "init refreshes",
        {logCode[1], logCode[2]}, 8'h11);
    chk(logCode[3] == 4'b0000 && !logBa[3], "R2", "init mode write", {logCode[3], logBa[3]}, 0);
    chk(logCode[4] == 4'b0000 && logBa[4], "R2", "init extended mode write",
        {logCode[4], logBa[4]}, 1);

    // writes across both banks and address corners
    access(1, 20'h00000, 16'h1111);
    access(1, 20'hFFFFF, 16'h2222);
    access(1, 20'h80000, 16'h3333);
    access(1, 20'h7FFFF, 16'h4444);
    access(1, 20'h12345, 16'hA5A5);
    access(1, 20'h9ABCD, 16'h5A5A);
    // reads in a different order, one unwritten word, overwrite
    access(0, 20'h7FFFF, 0);
    access(0, 20'h00000, 0);
    access(0, 20'h9ABCD, 0);
    access(0, 20'h55555, 0);
    access(1, 20'h00000, 16'hBEEF);
    access(0, 20'h00000, 0);
    access(0, 20'hFFFFF, 0);
    access(0, 20'h80000, 0);
    access(0, 20'h12345, 0);
    repeat (10) @(negedge clk);
    chk(expQ.size() == 0, "R5", "read results outstanding", expQ.size(), 0);

    // refresh rate while idle
    r0 = refCount;
    repeat (600) @(negedge clk);
    chk(refCount - r0 >= 3 && refCount - r0 <= 5, "R8", "refresh count in 600 cycles",
        refCount - r0, 4);

    // power-down with refresh wake-ups
    pdReq = 1;
    repeat (5) @(negedge clk);
    chk(!sdCke, "R9", "cke low in power-down", sdCke, 0);
    r0 = refCount;
    repeat (400) @(negedge clk);
    chk(refCount - r0 >= 2, "R9", "refresh during power-down", refCount - r0, 2);
    repeat (20) @(negedge clk);
    chk(!sdCke, "R9", "cke low again after refresh", sdCke, 0);

    // request while power-down is requested
    access(0, 20'h9ABCD, 0);
    access(1, 20'h3C3C3, 16'h0F0F);
    access(0, 20'h3C3C3, 0);
    repeat (10) @(negedge clk);
    chk(expQ.size() == 0, "R10", "reads served under pdReq", expQ.size(), 0);

    pdReq = 0;
    repeat (4) @(negedge clk);
    chk(sdCke, "R9", "cke high after pdReq drops", sdCke, 1);
    access(0, 20'hFFFFF, 0);
    repeat (10) @(negedge clk);
    chk(expQ.size() == 0, "R5", "final read drained", expQ.size(), 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 100000, 0);
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule